// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Peripheral Interface

This block sits on the device side of a bus whose low address byte and data byte share the same eight wires. While the strobe `ale` is high, it samples the low address byte from the shared bus, the high address byte from its own pins and the three cycle-status lines. When `ale` falls, it holds the values it last sampled. The held status is decoded into a cycle kind (memory read, opcode fetch, memory write, I/O read, I/O write, interrupt acknowledge, halt). The held address is compared against a window set by parameters. If the cycle kind and the address both match, the block is selected.

A selected read cycle returns a byte from a small local register file while the read strobe is low. A selected write cycle stores the byte that was on the bus just before the write strobe rises. Every selected access is stretched: `ready` is pulled low for a number of clocks fixed by a parameter. All bus inputs are assumed to be synchronous to `clk`. The shared bus is presented as separate in, out and enable signals.

Top module: `mbus_periph`

## Requirements
- R1: While and just after reset, `ready` is 1 and `ad_oe` is 0.
- R2: The address used for a cycle is {`a_hi`,`ad_in`} as sampled at the last clock edge where `ale` was 1. Changes on `ad_in` after `ale` falls do not move the address.
- R3: The status {`io_m`,`st1`,`st0`} is held in the same way and decoded as follows: 010 and 011 are memory reads, 001 is a memory write, 110 is an I/O read and 101 is an I/O write.
- R4: Codes 111, 000 and 100 never select the block. In those cycles there is no read drive, no store and no wait state.
- R5: The window is BASE_ADDR with its low IDX_W bits ignored. A memory-space instance compares all 16 address bits; an I/O-space instance compares only the low byte. The low IDX_W address bits pick the register.
- R6: In a selected read cycle, `ad_oe` goes to 1 in the clock after `rd_n` is sampled low, and back to 0 in the clock after `rd_n` is sampled high. While `ad_oe` is 1, `ad_out` carries the addressed register.
- R7: A selected write stores the last `ad_in` value sampled while `wr_n` was 0. The store happens at the clock edge where `wr_n` is first sampled 1 again, so data present after the rising edge of `wr_n` is ignored.
- R8: In a selected cycle, `ready` is 0 for exactly WAIT_CYCLES consecutive clocks (0 to 7), starting at the second clock edge after `ale` is sampled low. It is 1 afterwards. If WAIT_CYCLES is 0, `ready` never goes low.
- R9: `ready` stays 1 in every cycle that does not select the block, and it goes to 1 in the clock after `ale` is sampled high.
- R10: In a write-type cycle (`st1` = 0), `ad_oe` stays 0 even if `rd_n` is low.
- R11: A memory-space instance ignores I/O cycles, even when the address would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; the address is sampled while it is high |
| ad_in | input | 8 | Shared bus as seen by the block (low address, then data) |
| a_hi | input | 8 | High address byte |
| io_m | input | 1 | Status: 1 = I/O cycle, 0 = memory cycle |
| st1 | input | 1 | Status bit 1: 1 = read kind, 0 = write kind |
| st0 | input | 1 | Status bit 0 |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_out | output | 8 | Read data to be placed on the shared bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ready | output | 1 | 0 = hold the current access |

## Verification
Two functions can act in the same clock: the wait-state counter and a strobe. The bench lowers `rd_n` or `wr_n` in the clock right after the last wait state, and it lets a write strobe rise in the same clock that fresh bytes appear on `ad_in`. The monitor judges each read by the byte on `ad_out` when `ad_oe` first goes high, checked against a scoreboard queue. Each write is judged by reading it back. A write that should have been ignored is caught when a later read of the aliased register still returns the old byte.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_MRD,
    CYC_FETCH,
    CYC_MWR,
    CYC_IRD,
    CYC_IWR,
    CYC_INTA,
    CYC_HALT
  } cyc_e;

  // status bits ordered {io_m, st1, st0}
  function automatic cyc_e cyc_decode(input logic [2:0] st);
    case (st)
      3'b010:  return CYC_MRD;
      3'b011:  return CYC_FETCH;
      3'b001:  return CYC_MWR;
      3'b110:  return CYC_IRD;
      3'b101:  return CYC_IWR;
      3'b111:  return CYC_INTA;
      3'b000:  return CYC_HALT;
      default: return CYC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mbus_latch.sv
module mbus_latch #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic [BW-1:0] ad_in,
  input  logic [AW-BW-1:0] a_hi,
  input  logic [2:0]    stat_in,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    stat_o
);

  // follow the bus while the strobe is high, freeze on its fall
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      stat_o <= '0;
    end else if (ale) begin
      addr_o <= {a_hi, ad_in};
      stat_o <= stat_in;
    end
  end

  // R2: held address is frozen once the strobe was low
  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(ale) && !$past(rst)) |-> ($stable(addr_o) && $stable(stat_o)));

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
  import mbus_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          IDX_W     = 3,
  parameter logic [15:0] BASE_ADDR = 16'h4000,
  parameter bit          IO_SPACE  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ale,
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       stat,
  output logic             sel_rd,
  output logic             sel_wr,
  output logic [IDX_W-1:0] idx
);

  cyc_e cyc;
  logic hit;
  logic kind_rd;
  logic kind_wr;

  assign cyc = cyc_decode(stat);

  generate
    if (IO_SPACE) begin : g_io
      assign hit     = (addr[7:IDX_W] == BASE_ADDR[7:IDX_W]);
      assign kind_rd = (cyc == CYC_IRD);
      assign kind_wr = (cyc == CYC_IWR);
    end else begin : g_mem
      assign hit     = (addr[AW-1:IDX_W] == BASE_ADDR[AW-1:IDX_W]);
      assign kind_rd = (cyc == CYC_MRD) || (cyc == CYC_FETCH);
      assign kind_wr = (cyc == CYC_MWR);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || ale) begin
      sel_rd <= 1'b0;
      sel_wr <= 1'b0;
    end else begin
      sel_rd <= hit && kind_rd;
      sel_wr <= hit && kind_wr;
    end
    idx <= addr[IDX_W-1:0];
  end

  // R3: a cycle is never both read and write
  p_sel_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(sel_rd && sel_wr));

endmodule

// File: rtl/mbus_wait.sv
module mbus_wait #(
  parameter int WAIT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  logic sel,
  output logic ready
);

  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] WAIT_L = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt;
  logic             stall;

  assign stall = sel && !ale && (cnt < WAIT_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b1;
    end else begin
      if (ale)
        cnt <= '0;
      else if (stall)
        cnt <= cnt + 1'b1;
      ready <= !stall;
    end
  end

  // R9: a new address strobe releases the bus at once
  p_ale_release_r9: assert property (@(posedge clk) disable iff (rst)
    ale |=> ready);

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mbus_periph.sv
module mbus_periph #(
  parameter logic [15:0] BASE_ADDR   = 16'h4000,
  parameter int          IDX_W       = 3,
  parameter bit          IO_SPACE    = 1'b0,
  parameter int          WAIT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ale,
  input  logic [7:0] ad_in,
  input  logic [7:0] a_hi,
  input  logic       io_m,
  input  logic       st1,
  input  logic       st0,
  input  logic       rd_n,
  input  logic       wr_n,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  output logic       ready
);

  localparam int AW = 16;
  localparam int DW = 8;

  logic [AW-1:0]    lat_addr;
  logic [2:0]       lat_stat;
  logic             sel_rd;
  logic             sel_wr;
  logic [IDX_W-1:0] idx;
  logic             wr_q;
  logic [DW-1:0]    wdata_q;
  logic             we;

  mbus_latch #(.AW(AW), .BW(DW)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .stat_in({io_m, st1, st0}), .addr_o(lat_addr), .stat_o(lat_stat)
  );

  mbus_decode #(
    .AW(AW), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR), .IO_SPACE(IO_SPACE)
  ) u_decode (
    .clk(clk), .rst(rst), .ale(ale), .addr(lat_addr), .stat(lat_stat),
    .sel_rd(sel_rd), .sel_wr(sel_wr), .idx(idx)
  );

  mbus_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .ale(ale), .sel(sel_rd || sel_wr), .ready(ready)
  );

  // write data follows the bus while the strobe is low; commit on its rise
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= 1'b1;
      wdata_q <= '0;
    end else begin
      wr_q <= wr_n;
      if (!wr_n)
        wdata_q <= ad_in;
    end
  end

  assign we = sel_wr && !wr_q && wr_n;

  mbus_regfile #(.DW(DW), .AW(IDX_W)) u_rf (
    .clk(clk), .we(we), .waddr(idx), .wdata(wdata_q),
    .raddr(idx), .rdata(ad_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ad_oe <= 1'b0;
    else
      ad_oe <= sel_rd && !rd_n;
  end

  // R6: drive only after a sampled read strobe
  p_oe_after_rd_r6: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> $past(!rd_n));

  // R10: never drive during a write-kind cycle
  p_no_oe_write_r10: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> lat_stat[1]);

  // R8: run of low ready never exceeds the configured count
  logic [3:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || ready)
      low_run <= '0;
    else
      low_run <= low_run + 1'b1;
  end

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (rst)
    low_run <= 4'(WAIT_CYCLES));

endmodule

// File: tb/mbus_periph_test.sv
module mbus_periph_test;

  localparam int W = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       ale;
  logic [7:0] ad_in;
  logic [7:0] a_hi;
  logic       io_m, st1, st0;
  logic       rd_n, wr_n;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       oe_prev = 1'b0;

  always #5 clk = ~clk;

  mbus_periph #(.BASE_ADDR(16'h4000), .IDX_W(3), .IO_SPACE(1'b0),
                .WAIT_CYCLES(W)) uut (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .io_m(io_m), .st1(st1), .st0(st0), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ready(ready)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data when the drive enable first rises
  always @(negedge clk) begin
    if (!rst) begin
      if (ad_oe && !oe_prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4 R10 R11 unexpected drive actual=%h expected=none",
                   ad_out);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (ad_out !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, ad_out, e);
          end
        end
      end
      oe_prev = ad_oe;
    end
  end

  task automatic bus_cycle(input logic [2:0] st, input logic [15:0] addr,
                           input bit do_rd, input bit do_wr,
                           input logic [7:0] wd, input bit exp_sel,
                           input bit exp_oe, input logic [7:0] exp_rd,
                           input string tag);
    @(negedge clk);
    ale = 1'b1; ad_in = addr[7:0]; a_hi = addr[15:8];
    {io_m, st1, st0} = st;
    @(negedge clk);
    ale = 1'b0; ad_in = 8'hEE;   // R2: low byte leaves the bus
    for (int i = 0; i <= W + 1; i++) begin
      @(negedge clk);
      check({7'd0, ready},
            {7'd0, !(exp_sel && i >= 1 && i <= W)},
            exp_sel ? "R8 ready window" : "R9 ready idle");
    end
    if (do_rd) begin
      if (exp_oe) begin
        exp_q.push_back(exp_rd);
        tag_q.push_back(tag);
      end
      rd_n = 1'b0;
      repeat (2) @(negedge clk);
      rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check({7'd0, ad_oe}, 8'd0, "R6 drive released");
    end
    if (do_wr) begin
      ad_in = wd; wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1; ad_in = 8'h5A;   // R7: late bus value must be ignored
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1; ale = 1'b0; ad_in = '0; a_hi = '0;
    io_m = 1'b0; st1 = 1'b0; st0 = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check({7'd0, ready}, 8'd1, "R1 ready in reset");
    check({7'd0, ad_oe}, 8'd0, "R1 oe in reset");
    rst = 1'b0;
    @(negedge clk);
    check({7'd0, ready}, 8'd1, "R1 ready after reset");
    check({7'd0, ad_oe}, 8'd0, "R1 oe after reset");

    // R3 R7 writes, R2 address survives bus change
    bus_cycle(3'b001, 16'h4003, 0, 1, 8'hA5, 1, 0, 8'h00, "R3");
    bus_cycle(3'b001, 16'h4000, 0, 1, 8'h3C, 1, 0, 8'h00, "R3");
    bus_cycle(3'b001, 16'h4007, 0, 1, 8'h77, 1, 0, 8'h00, "R2");
    // R3 R6 memory read and opcode fetch
    bus_cycle(3'b010, 16'h4003, 1, 0, 8'h00, 1, 1, 8'hA5, "R3 R6 mem read");
    bus_cycle(3'b011, 16'h4000, 1, 0, 8'h00, 1, 1, 8'h3C, "R3 R6 fetch");
    bus_cycle(3'b010, 16'h4007, 1, 0, 8'h00, 1, 1, 8'h77, "R2 R7 readback");
    // R5 out of window writes, aliasing registers 0 and 3
    bus_cycle(3'b001, 16'h4008, 0, 1, 8'hFF, 0, 0, 8'h00, "R5");
    bus_cycle(3'b001, 16'h3FFB, 0, 1, 8'h11, 0, 0, 8'h00, "R5");
    bus_cycle(3'b010, 16'h4010, 1, 0, 8'h00, 0, 0, 8'h00, "R5");
    bus_cycle(3'b010, 16'h4000, 1, 0, 8'h00, 1, 1, 8'h3C, "R5 no alias write");
    bus_cycle(3'b010, 16'h4003, 1, 0, 8'h00, 1, 1, 8'hA5, "R5 no alias write");
    // R11 I/O cycles ignored by memory-space instance
    bus_cycle(3'b101, 16'h4003, 0, 1, 8'h22, 0, 0, 8'h00, "R11");
    bus_cycle(3'b110, 16'h4003, 1, 0, 8'h00, 0, 0, 8'h00, "R11");
    // R4 halt, interrupt acknowledge and unused code
    bus_cycle(3'b000, 16'h4003, 0, 1, 8'h33, 0, 0, 8'h00, "R4");
    bus_cycle(3'b111, 16'h4003, 1, 0, 8'h00, 0, 0, 8'h00, "R4");
    bus_cycle(3'b100, 16'h4003, 1, 1, 8'h44, 0, 0, 8'h00, "R4");
    // R10 read strobe during a write-kind cycle
    bus_cycle(3'b001, 16'h4005, 1, 0, 8'h00, 1, 0, 8'h00, "R10");
    bus_cycle(3'b010, 16'h4003, 1, 0, 8'h00, 1, 1, 8'hA5,
              "R4 R11 no stray write");

    repeat (3) @(negedge clk);
    check(8'(exp_q.size()), 8'd0, "R6 all reads seen");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule